// File: doc/BRIEF.md
# Lockstep Dual-Timer Single-Edge PWM

This block holds two identical PWM timer units, A and B, driven from one clock. Each unit has its own prescaler, a cycle counter, a period match (match 0) and six duty match registers, each feeding one single-edge output. One shared hold bit freezes both counters. While it is set, software configures both units at leisure. Clearing it starts both counters on the same clock edge, so the two output groups keep a fixed phase relation to each other.

Software loads every setting through a one-cycle write strobe that carries a unit select, an address and data. A match write can take effect at once. It can also be parked in a shadow copy that moves to the live register when the counter next restarts, so a duty or period change never splits a PWM cycle. Each match slot can raise a sticky flag, restart the counter, or stop the counter. With the usual setup, match 0 restarts the counter and only unit A flags its period match.

Top module: `dual_pwm_sync`

## Requirements
- R1: Write interface. A write is a one-cycle `wr_en` pulse. `wr_unit` selects the unit (0 = A, 1 = B), and a write to one unit leaves the other unit unchanged. Addresses:
  - 0: control. bit0 = count enable, bit1 = PWM enable, bit2 = counter-restart command.
  - 1: prescale value P.
  - 2+k: match k, for k = 0..6.
  - 9: match actions. Bit 3k enables the flag for match k, bit 3k+1 enables restart on match k, bit 3k+2 enables stop on match k.
  - 10: output enables, bit k-1 for channel k.
  - 11: flag clear, bit k.
  - 12: shared hold bit, in bit0, for either unit.
- R2: After reset, all outputs are low, both counters and all flags are 0, and the shared hold bit is 1. Setting count enable alone therefore does not start a counter.
- R3: While the hold bit is 1, neither counter changes and every PWM output is low, even with count enable and PWM enable set.
- R4: Clearing the hold bit starts both enabled units on the same edge. Two units with equal prescale and period show equal counters on every cycle that follows.
- R5: Each count value lasts P+1 clocks. With restart on match 0 and period value M0, the counter runs 0, 1, ..., M0 and then returns to 0.
- R6: Channel k is high while the counter is below its duty D. Over one period it is high for min(D, M0+1)·(P+1) clocks. This gives D = 0 never high, and D ≥ M0+1 high for the whole period.
- R7: A match write with `wr_imm` = 1 changes the live value on the next clock.
- R8: A match write with `wr_imm` = 0 leaves the live value unchanged until the next counter restart, then applies the new value.
- R9: When match k is reached and its flag is enabled, flag k becomes 1. It stays 1 until a 1 is written to its clear bit. `irq_x` is high whenever any flag of that unit is set.
- R10: Reaching a match with stop enabled clears count enable. The counter then holds its value and the outputs of that unit go low.
- R11: The restart command zeroes the counter and the prescale divider on the next clock.
- R12: A channel whose output enable is 0 drives low, whatever its duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both units |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_unit | input | 1 | Unit select, 0 = A, 1 = B |
| wr_addr | input | 4 | Register address |
| wr_data | input | DW (32) | Write data |
| wr_imm | input | 1 | Match write applies at once (1) or at next restart (0) |
| pwm_a | output | NCH (6) | Unit A channel outputs, bit k-1 = channel k |
| pwm_b | output | NCH (6) | Unit B channel outputs |
| irq_a | output | 1 | Any unit A flag set |
| irq_b | output | 1 | Any unit B flag set |
| flags_a | output | NCH+1 (7) | Unit A sticky match flags, bit k = match k |
| flags_b | output | NCH+1 (7) | Unit B sticky match flags |
| cnt_a | output | CW (16) | Unit A cycle counter |
| cnt_b | output | CW (16) | Unit B cycle counter |

## Verification
A divider or counter that drifts in one unit makes `cnt_a` and `cnt_b` differ on the first cycle after release. A wrong prescale or wrap point misplaces the counter sequence within one count period. A live match register holding the wrong value changes the high-time of its channel in the very period it is loaded. A shadow that is applied too early shows up as a changed output level before the counter next restarts. Flag or stop faults appear at the ports one clock after the match cycle, as a missing or stuck flag or a counter that keeps moving.

// File: rtl/pwm_sync_pkg.sv
`timescale 1ns/1ps
package pwm_sync_pkg;
   localparam int MAX_CH = 6;
   localparam int AW     = 4;

   localparam logic [AW-1:0] ADDR_CTL  = 4'd0;
   localparam logic [AW-1:0] ADDR_PRE  = 4'd1;
   localparam logic [AW-1:0] ADDR_M0   = 4'd2;
   localparam logic [AW-1:0] ADDR_MACT = 4'd9;
   localparam logic [AW-1:0] ADDR_OE   = 4'd10;
   localparam logic [AW-1:0] ADDR_CLR  = 4'd11;
   localparam logic [AW-1:0] ADDR_HOLD = 4'd12;

   localparam int CTL_CEN = 0;
   localparam int CTL_PEN = 1;
   localparam int CTL_RST = 2;

   localparam int ACT_FLAG = 0;
   localparam int ACT_RST  = 1;
   localparam int ACT_STOP = 2;
   localparam int ACT_BITS = 3;
endpackage

// File: rtl/pwm_prescale.sv
`timescale 1ns/1ps
module pwm_prescale #(
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          clr,
   input  logic [PW-1:0] div,
   output logic          tick
);
   logic [PW-1:0] pc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc <= '0;
      else if (clr)
         pc <= '0;
      else if (run)
         pc <= (pc == div) ? '0 : pc + 1'b1;
   end

   assign tick = run && !clr && (pc == div);
endmodule

// File: rtl/pwm_match_bank.sv
`timescale 1ns/1ps
module pwm_match_bank #(
   parameter int CW        = 16,
   parameter int NM        = 7,
   parameter bit SHADOW_EN = 1'b1,
   localparam int IW       = (NM > 1) ? $clog2(NM) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [IW-1:0]          idx,
   input  logic [CW-1:0]          data,
   input  logic                   imm,
   input  logic                   apply,
   output logic [NM-1:0][CW-1:0]  act
);
   for (genvar k = 0; k < NM; k++) begin : g_slot
      logic hit_w;
      assign hit_w = we && (idx == IW'(k));
      if (SHADOW_EN) begin : g_shadow
         logic [CW-1:0] shadow;
         logic          pend;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shadow <= '0;
               pend   <= 1'b0;
               act[k] <= '0;
            end else if (hit_w) begin
               shadow <= data;
               if (imm) begin
                  act[k] <= data;
                  pend   <= 1'b0;
               end else begin
                  pend   <= 1'b1;
               end
            end else if (apply && pend) begin
               act[k] <= shadow;
               pend   <= 1'b0;
            end
         end
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               act[k] <= '0;
            else if (hit_w)
               act[k] <= data;
         end
      end
   end
endmodule

// File: rtl/pwm_unit.sv
`timescale 1ns/1ps
module pwm_unit
   import pwm_sync_pkg::*;
#(
   parameter int CW        = 16,
   parameter int PW        = 8,
   parameter int DW        = 32,
   parameter int NCH       = 6,
   parameter bit SHADOW_EN = 1'b1,
   localparam int NM       = NCH + 1,
   localparam int IW       = $clog2(NM)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hold,
   input  logic                  we,
   input  logic [AW-1:0]         addr,
   input  logic [DW-1:0]         data,
   input  logic                  imm,
   output logic [NCH-1:0]        pwm,
   output logic [NM-1:0]         flags,
   output logic                  irq,
   output logic [CW-1:0]         cnt,
   output logic [NM-1:0][CW-1:0] act
);
   logic                 cen, pen;
   logic [PW-1:0]        div;
   logic [ACT_BITS*NM-1:0] mact;
   logic [NCH-1:0]       oe;
   logic                 run, tick, clr_cmd;
   logic [NM-1:0]        hit, en_flag, en_rst, en_stop;
   logic                 rst_hit, stop_hit, apply;
   logic                 m_we;
   logic [AW-1:0]        m_off;
   logic [NM-1:0]        clr_mask;
   logic                 unused_data;

   assign unused_data = ^data;

   assign run     = cen && !hold;
   assign clr_cmd = we && (addr == ADDR_CTL) && data[CTL_RST];
   assign m_off   = addr - ADDR_M0;
   assign m_we    = we && (addr >= ADDR_M0) && (m_off < AW'(NM));
   assign clr_mask = (we && addr == ADDR_CLR) ? data[NM-1:0] : '0;

   // control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cen  <= 1'b0;
         pen  <= 1'b0;
         div  <= '0;
         mact <= '0;
         oe   <= '0;
      end else begin
         if (we && addr == ADDR_CTL) begin
            cen <= data[CTL_CEN];
            pen <= data[CTL_PEN];
         end else if (stop_hit) begin
            cen <= 1'b0;
         end
         if (we && addr == ADDR_PRE)  div  <= data[PW-1:0];
         if (we && addr == ADDR_MACT) mact <= data[ACT_BITS*NM-1:0];
         if (we && addr == ADDR_OE)   oe   <= data[NCH-1:0];
      end
   end

   pwm_prescale #(.PW(PW)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .clr  (clr_cmd),
      .div  (div),
      .tick (tick)
   );

   pwm_match_bank #(.CW(CW), .NM(NM), .SHADOW_EN(SHADOW_EN)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (m_we),
      .idx  (m_off[IW-1:0]),
      .data (data[CW-1:0]),
      .imm  (imm),
      .apply(apply),
      .act  (act)
   );

   for (genvar k = 0; k < NM; k++) begin : g_match
      assign en_flag[k] = mact[ACT_BITS*k + ACT_FLAG];
      assign en_rst[k]  = mact[ACT_BITS*k + ACT_RST];
      assign en_stop[k] = mact[ACT_BITS*k + ACT_STOP];
      assign hit[k]     = tick && (cnt == act[k]);
   end

   assign rst_hit  = |(hit & en_rst);
   assign stop_hit = |(hit & en_stop);
   assign apply    = clr_cmd || rst_hit;

   // cycle counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr_cmd)
         cnt <= '0;
      else if (tick) begin
         if (rst_hit)
            cnt <= '0;
         else if (!stop_hit)
            cnt <= cnt + 1'b1;
      end
   end

   // sticky flags, cleared by writing ones
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags <= '0;
      else
         flags <= (flags & ~clr_mask) | (hit & en_flag);
   end

   assign irq = |flags;

   // single-edge outputs: high while the count is below the duty value
   for (genvar c = 1; c <= NCH; c++) begin : g_out
      assign pwm[c-1] = run && pen && oe[c-1] && (cnt < act[c]);
   end
endmodule

// File: rtl/dual_pwm_sync.sv
`timescale 1ns/1ps
module dual_pwm_sync
   import pwm_sync_pkg::*;
#(
   parameter int CW        = 16,
   parameter int PW        = 8,
   parameter int DW        = 32,
   parameter int NCH       = 6,
   parameter bit SHADOW_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            wr_unit,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic            wr_imm,
   output logic [NCH-1:0]  pwm_a,
   output logic [NCH-1:0]  pwm_b,
   output logic            irq_a,
   output logic            irq_b,
   output logic [NCH:0]    flags_a,
   output logic [NCH:0]    flags_b,
   output logic [CW-1:0]   cnt_a,
   output logic [CW-1:0]   cnt_b
);
   localparam int NUNIT = 2;
   localparam int NM    = NCH + 1;

   if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
      $error("NCH must lie in 1..%0d", MAX_CH);
   end
   if (CW > DW || PW > DW) begin : g_bad_width
      $error("CW and PW must not exceed DW");
   end
   if (ACT_BITS * NM > DW) begin : g_bad_act
      $error("match action field does not fit in DW");
   end

   logic                          hold_q;
   logic [NUNIT-1:0][NCH-1:0]     pwm_u;
   logic [NUNIT-1:0][NM-1:0]      flg_u;
   logic [NUNIT-1:0]              irq_u;
   logic [NUNIT-1:0][CW-1:0]      cnt_u;
   logic [NUNIT-1:0][NM-1:0][CW-1:0] act_match;

   // shared hold bit, set out of reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= 1'b1;
      else if (wr_en && wr_addr == ADDR_HOLD)
         hold_q <= wr_data[0];
   end

   for (genvar u = 0; u < NUNIT; u++) begin : g_unit
      logic sel;
      assign sel = wr_en && (wr_unit == 1'(u)) && (wr_addr != ADDR_HOLD);
      pwm_unit #(
         .CW(CW), .PW(PW), .DW(DW), .NCH(NCH), .SHADOW_EN(SHADOW_EN)
      ) u_unit (
         .clk  (clk),
         .rst_n(rst_n),
         .hold (hold_q),
         .we   (sel),
         .addr (wr_addr),
         .data (wr_data),
         .imm  (wr_imm),
         .pwm  (pwm_u[u]),
         .flags(flg_u[u]),
         .irq  (irq_u[u]),
         .cnt  (cnt_u[u]),
         .act  (act_match[u])
      );
   end

   assign pwm_a   = pwm_u[0];
   assign pwm_b   = pwm_u[1];
   assign flags_a = flg_u[0];
   assign flags_b = flg_u[1];
   assign irq_a   = irq_u[0];
   assign irq_b   = irq_u[1];
   assign cnt_a   = cnt_u[0];
   assign cnt_b   = cnt_u[1];
endmodule

// File: rtl/pwm_sync_chk.sv
`timescale 1ns/1ps
module pwm_sync_chk
   import pwm_sync_pkg::*;
#(
   parameter int CW  = 16,
   parameter int DW  = 32,
   parameter int NCH = 6
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        wr_en,
   input logic                        wr_unit,
   input logic [AW-1:0]               wr_addr,
   input logic [DW-1:0]               wr_data,
   input logic                        hold,
   input logic [NCH-1:0]              pwm_a,
   input logic [NCH-1:0]              pwm_b,
   input logic [NCH:0]                flags_a,
   input logic [NCH:0]                flags_b,
   input logic [CW-1:0]               cnt_a,
   input logic [CW-1:0]               cnt_b,
   input logic [1:0][NCH:0][CW-1:0]   act_all
);
   logic unused_chk;
   assign unused_chk = ^wr_data;

   // R3
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold && $past(hold) && !$past(wr_en) |-> $stable(cnt_a) && $stable(cnt_b));

   // R3
   hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> (pwm_a == '0) && (pwm_b == '0));

   // R11
   restart_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && !wr_unit && wr_addr == ADDR_CTL && wr_data[CTL_RST]) |-> cnt_a == '0);

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en && wr_addr == ADDR_CLR) |->
         ((flags_a & $past(flags_a)) == $past(flags_a)) &&
         ((flags_b & $past(flags_b)) == $past(flags_b)));

   for (genvar c = 1; c <= NCH; c++) begin : g_zero
      // R6
      zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (act_all[0][c] == '0) |-> !pwm_a[c-1]);
   end
endmodule

bind dual_pwm_sync pwm_sync_chk #(.CW(CW), .DW(DW), .NCH(NCH)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .wr_unit(wr_unit),
   .wr_addr(wr_addr),
   .wr_data(wr_data),
   .hold   (hold_q),
   .pwm_a  (pwm_a),
   .pwm_b  (pwm_b),
   .flags_a(flags_a),
   .flags_b(flags_b),
   .cnt_a  (cnt_a),
   .cnt_b  (cnt_b),
   .act_all(act_match)
);

// File: tb/tb_dual_pwm_sync.sv
`timescale 1ns/1ps
module tb_dual_pwm_sync;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_unit = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        wr_imm = 1'b0;
   logic [5:0]  pwm_a, pwm_b;
   logic        irq_a, irq_b;
   logic [6:0]  flags_a, flags_b;
   logic [15:0] cnt_a, cnt_b;

   int total = 0;
   int bad = 0;
   bit done = 0;
   int duty [0:1][1:6];

   dual_pwm_sync dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_unit(wr_unit),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_imm(wr_imm),
      .pwm_a(pwm_a), .pwm_b(pwm_b), .irq_a(irq_a), .irq_b(irq_b),
      .flags_a(flags_a), .flags_b(flags_b), .cnt_a(cnt_a), .cnt_b(cnt_b)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int u, input int a, input int d, input bit imm);
      @(negedge clk);
      wr_en = 1'b1; wr_unit = u[0]; wr_addr = a[3:0]; wr_data = d; wr_imm = imm;
      @(negedge clk);
      wr_en = 1'b0; wr_imm = 1'b0;
   endtask

   task automatic wait_cnt_a(input int v);
      int n = 0;
      while (cnt_a != 16'(v) && n < 500) begin
         @(negedge clk);
         n++;
      end
   endtask

   function automatic int exp_high(input int d, input int m0, input int p);
      return ((d < m0 + 1) ? d : m0 + 1) * (p + 1);
   endfunction

   task automatic run_round(input int p, input int m0);
      int hi [0:1][1:6];
      int mism = 0;
      int seq_err = 0;
      int len = (m0 + 1) * (p + 1);
      wr(0, 12, 1, 1);
      for (int u = 0; u < 2; u++) begin
         wr(u, 1, p, 1);
         wr(u, 2, m0, 1);
         for (int k = 1; k <= 6; k++) wr(u, 2 + k, duty[u][k], 1);
         wr(u, 9, (u == 0) ? 3 : 2, 1);
         wr(u, 10, 6'h3f, 1);
         wr(u, 11, 7'h7f, 1);
         wr(u, 0, 7, 1);
      end
      repeat (4) @(negedge clk);
      // R3: held counters and quiet outputs
      chk(cnt_a == 0 && cnt_b == 0, "R3 counters held", int'(cnt_a) + int'(cnt_b), 0);
      chk(pwm_a == 0 && pwm_b == 0, "R3 outputs low while held", int'({pwm_a, pwm_b}), 0);
      for (int u = 0; u < 2; u++) for (int k = 1; k <= 6; k++) hi[u][k] = 0;
      wr(0, 12, 0, 1);
      for (int i = 0; i < len; i++) begin
         if (cnt_a != cnt_b) mism++;
         if (int'(cnt_a) != i / (p + 1)) seq_err++;
         for (int k = 1; k <= 6; k++) begin
            if (pwm_a[k-1]) hi[0][k]++;
            if (pwm_b[k-1]) hi[1][k]++;
         end
         @(negedge clk);
      end
      chk(mism == 0, "R4 lockstep counters", mism, 0);
      chk(seq_err == 0, "R5 count sequence", seq_err, 0);
      chk(cnt_a == 0, "R5 wrap after period", int'(cnt_a), 0);
      for (int k = 1; k <= 6; k++) begin
         chk(hi[0][k] == exp_high(duty[0][k], m0, p), "R6 unit A high time",
             hi[0][k], exp_high(duty[0][k], m0, p));
         chk(hi[1][k] == exp_high(duty[1][k], m0, p), "R1 unit B own duty",
             hi[1][k], exp_high(duty[1][k], m0, p));
      end
      chk(flags_a[0] == 1'b1 && irq_a, "R9 period flag A", int'(flags_a[0]), 1);
      chk(!irq_b && flags_b == 0, "R9 no flag B", int'(flags_b), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int m0, p;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: reset state
      chk(pwm_a == 0 && pwm_b == 0, "R2 outputs low", int'({pwm_a, pwm_b}), 0);
      chk(cnt_a == 0 && cnt_b == 0, "R2 counters zero", int'(cnt_a) + int'(cnt_b), 0);
      chk(flags_a == 0 && flags_b == 0 && !irq_a && !irq_b, "R2 flags clear",
          int'({flags_a, flags_b}), 0);
      wr(0, 0, 3, 1);
      repeat (10) @(negedge clk);
      chk(cnt_a == 0, "R2 hold bit set from reset", int'(cnt_a), 0);

      // directed round covering duty corners
      duty[0] = '{0, 5, 10, 15, 1, 9};
      duty[1] = '{3, 0, 9, 10, 12, 2};
      run_round(1, 9);

      // random rounds
      for (int r = 0; r < 3; r++) begin
         p  = $urandom % 3;
         m0 = 4 + $urandom % 9;
         for (int u = 0; u < 2; u++)
            for (int k = 1; k <= 6; k++) duty[u][k] = $urandom % (m0 + 4);
         run_round(p, m0);
      end

      // final directed round as base for the remaining cases
      duty[0] = '{0, 5, 10, 15, 1, 9};
      duty[1] = '{3, 0, 9, 10, 12, 2};
      run_round(1, 9);
      wr(0, 11, 1, 1);
      chk(flags_a[0] == 1'b0 && !irq_a, "R9 write-one clear", int'(flags_a[0]), 0);

      // R8: deferred duty write on channel 2 (old 5, new 3)
      wait_cnt_a(1);
      wr(0, 4, 3, 0);
      wait_cnt_a(4);
      chk(pwm_a[1] == 1'b1, "R8 old duty kept until restart", int'(pwm_a[1]), 1);
      wait_cnt_a(0);
      wait_cnt_a(4);
      chk(pwm_a[1] == 1'b0, "R8 new duty after restart", int'(pwm_a[1]), 0);

      // R7: immediate duty write on channel 2 (now 3, new 7)
      wait_cnt_a(1);
      wr(0, 4, 7, 1);
      wait_cnt_a(6);
      chk(pwm_a[1] == 1'b1, "R7 immediate duty", int'(pwm_a[1]), 1);

      // R12: disable channel 6
      wr(0, 10, 6'h1f, 1);
      wait_cnt_a(2);
      chk(pwm_a[5] == 1'b0, "R12 disabled channel low", int'(pwm_a[5]), 0);
      chk(pwm_a[2] == 1'b1, "R12 enabled channel still high", int'(pwm_a[2]), 1);

      // R11: restart command clears counter and divider (P = 1)
      wait_cnt_a(5);
      wr(0, 0, 7, 1);
      chk(cnt_a == 0, "R11 counter cleared", int'(cnt_a), 0);
      @(negedge clk);
      chk(cnt_a == 0, "R11 divider restarted", int'(cnt_a), 0);
      @(negedge clk);
      chk(cnt_a == 1, "R11 first step after restart", int'(cnt_a), 1);

      // R10: stop on match 5 of unit B at value 4
      wr(1, 7, 4, 1);
      wr(1, 9, 2 | (1 << 17), 1);
      repeat (80) @(negedge clk);
      chk(cnt_b == 4, "R10 counter stopped", int'(cnt_b), 4);
      chk(pwm_b == 0, "R10 outputs low after stop", int'(pwm_b), 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule